// File: doc/BRIEF.md
# Debug Control Word with Breakpoint/Event Pins

This block holds a 32-bit debug control word that software writes and reads through a simple register port. Seven of its bits are live. The other 25 are reserved. The live bits enable last-branch recording, switch the trap-flag single-step to stepping on branches only, and enable trace messages. Four further bits each choose what one external pin reports.

The block drives four shared active-low pins. When a pin's select bit is set, the pin reports breakpoint-address matches for its own channel. Each match strobe produces a one-cycle low pulse, and the pulse restarts if another match arrives. When the select bit is clear, the pin follows the performance-event input for that channel. That input only drives the pin and changes no other state.

The breakpoint comparators, the event counters and the trace generator sit outside this block. They appear here only as strobes and enables. The block also decodes the trap flag against the branch-step bit, so that the stepping logic receives a single mode.

Top module: `dbgctl_pins`

## Requirements
- R1: After a synchronous reset, the word reads as zero, every enable output is low and all four pins are high.
- R2: Writes to bits 31:7 are ignored, and those bits always read as zero.
- R3: A write updates bits 6:0 at the clock edge where wr_en is high. Bit 0 drives branch_rec_en, bit 1 drives step_on_branch and bit 6 drives trace_msg_en.
- R4: Bits 2, 3, 4 and 5 select breakpoint mode for pins 0, 1, 2 and 3. A set bit means breakpoint mode and a clear bit means event mode.
- R5: In breakpoint mode, a bp_match strobe sampled at a clock edge drives that pin low for exactly one cycle, starting just after that edge. The pin is high otherwise.
- R6: A match strobe sampled while a pulse is active restarts the pulse, so matches on consecutive cycles keep the pin low without a gap.
- R7: In event mode, pin_n[i] equals the inverse of perf_evt[i] in the same cycle. Event activity does not change the word or the enable outputs.
- R8: Match strobes that arrive while a pin is in event mode have no effect. No pulse is left pending, so switching that pin to breakpoint mode afterwards leaves it high.
- R9: With trap_flag low, both step outputs are low. With trap_flag high, step_branch_only follows bit 1 and step_each_insn follows its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word with reserved bits zero |
| bp_match | input | 4 | Breakpoint-match strobes, one per channel |
| perf_evt | input | 4 | Performance-event signals, one per channel |
| pin_n | output | 4 | Active-low breakpoint/event pins |
| trap_flag | input | 1 | Trap flag from the execution state |
| branch_rec_en | output | 1 | Last-branch recording enable |
| step_on_branch | output | 1 | Branch-step mode bit |
| trace_msg_en | output | 1 | Trace-message enable |
| step_each_insn | output | 1 | Trap flag set, step every instruction |
| step_branch_only | output | 1 | Trap flag set, step on branches only |

## Verification
The hardest case to reach is a match strobe arriving while its pin is in event mode, followed by a switch of that pin to breakpoint mode. A stale pulse would show only in the cycle after the switch. The bench holds every match strobe high through a full sweep of event patterns. It then drops the strobes and writes all select bits set in the same cycle, and checks that every pin stays high. The run also walks all 128 values of the live bits with varied reserved-bit patterns, all 16 match patterns, and strobes held over several cycles.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;

    localparam int NUM_PINS = 4;
    localparam int CTL_W    = 7;
    localparam int SEL_LSB  = 2;

    typedef struct packed {
        logic                trace_en;
        logic [NUM_PINS-1:0] pin_sel;
        logic                step_br;
        logic                lbr_en;
    } ctl_t;

    typedef enum logic {
        PIN_PERF = 1'b0,
        PIN_BRK  = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic each_insn;
        logic branch_only;
    } step_t;

    function automatic step_t step_decode(input logic tf, input logic btf);
        step_t s;
        s.each_insn   = tf & ~btf;
        s.branch_only = tf & btf;
        return s;
    endfunction

    function automatic pin_mode_e mode_of(input logic sel_bit);
        return sel_bit ? PIN_BRK : PIN_PERF;
    endfunction

endpackage

// File: rtl/dbgctl_reg.sv
module dbgctl_reg
    import dbgctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam int RSVD_W = DATA_W - CTL_W;

    logic unused_rsvd;
    assign unused_rsvd = ^wr_data[DATA_W-1:CTL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
        end
    end

    assign rd_data = {{RSVD_W{1'b0}}, ctl_q};

endmodule

// File: rtl/dbgctl_pin.sv
module dbgctl_pin
    import dbgctl_pkg::*;
#(
    parameter int PULSE_W = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_brk,
    input  logic match,
    input  logic perf_evt,
    output logic pin_n
);

    localparam int CNT_W = $clog2(PULSE_W + 1);

    logic [CNT_W-1:0] cnt_q;
    pin_mode_e        mode;

    assign mode = mode_of(sel_brk);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (mode == PIN_PERF) begin
            cnt_q <= '0;
        end else if (match) begin
            cnt_q <= CNT_W'(PULSE_W);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            PIN_BRK:  pin_n = (cnt_q == '0);
            default:  pin_n = ~perf_evt;
        endcase
    end

endmodule

// File: rtl/dbgctl_step.sv
module dbgctl_step
    import dbgctl_pkg::*;
(
    input  logic trap_flag,
    input  logic step_br,
    output logic step_each_insn,
    output logic step_branch_only
);

    step_t s;

    always_comb begin
        s                = step_decode(trap_flag, step_br);
        step_each_insn   = s.each_insn;
        step_branch_only = s.branch_only;
    end

endmodule

// File: rtl/dbgctl_pins.sv
module dbgctl_pins
    import dbgctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PULSE_W = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] bp_match,
    input  logic [NUM_PINS-1:0] perf_evt,
    output logic [NUM_PINS-1:0] pin_n,
    input  logic                trap_flag,
    output logic                branch_rec_en,
    output logic                step_on_branch,
    output logic                trace_msg_en,
    output logic                step_each_insn,
    output logic                step_branch_only
);

    ctl_t ctl;

    dbgctl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl),
        .rd_data (rd_data)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        dbgctl_pin #(.PULSE_W(PULSE_W)) u_pin (
            .clk      (clk),
            .rst      (rst),
            .sel_brk  (ctl.pin_sel[i]),
            .match    (bp_match[i]),
            .perf_evt (perf_evt[i]),
            .pin_n    (pin_n[i])
        );
    end

    dbgctl_step u_step (
        .trap_flag        (trap_flag),
        .step_br          (ctl.step_br),
        .step_each_insn   (step_each_insn),
        .step_branch_only (step_branch_only)
    );

    assign branch_rec_en  = ctl.lbr_en;
    assign step_on_branch = ctl.step_br;
    assign trace_msg_en   = ctl.trace_en;

endmodule

// File: rtl/dbgctl_pins_chk.sv
module dbgctl_pins_chk
    import dbgctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PULSE_W = 1
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W-1:0]   rd_data,
    input logic [NUM_PINS-1:0] bp_match,
    input logic [NUM_PINS-1:0] perf_evt,
    input logic [NUM_PINS-1:0] pin_n,
    input logic                trap_flag,
    input logic                branch_rec_en,
    input logic                step_on_branch,
    input logic                trace_msg_en,
    input logic                step_each_insn,
    input logic                step_branch_only
);

    // R1: reset leaves word clear and pins idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && pin_n == '1));

    // R2: reserved field never reads nonzero
    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:CTL_W] == '0);

    // R3: write lands in the live bits
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[CTL_W-1:0] == $past(wr_data[CTL_W-1:0]));

    // R3: enables reflect the word
    a_r3_enable_map: assert property (@(posedge clk) disable iff (rst)
        branch_rec_en == rd_data[0] && step_on_branch == rd_data[1]
        && trace_msg_en == rd_data[6]);

    // R9: step modes are exclusive and follow the branch-step bit
    a_r9_step_mode: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_each_insn, step_branch_only})
        && (trap_flag == (step_each_insn | step_branch_only))
        && (!trap_flag || step_branch_only == rd_data[1]));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R5: sampled match gives a low pin on the next cycle
        a_r5_pulse_low: assert property (@(posedge clk) disable iff (rst)
            (rd_data[SEL_LSB+i] && !wr_en && bp_match[i]) |=> !pin_n[i]);

        // R6: a pulse ends after one cycle when no new match arrives
        if (PULSE_W == 1) begin : g_one
            a_r6_pulse_ends: assert property (@(posedge clk) disable iff (rst)
                (rd_data[SEL_LSB+i] && !wr_en && !bp_match[i]) |=> pin_n[i]);
        end

        // R7: event mode mirrors the event input
        a_r7_perf_follow: assert property (@(posedge clk) disable iff (rst)
            !rd_data[SEL_LSB+i] |-> (pin_n[i] == !perf_evt[i]));

        // R8: nothing left pending from event mode
        a_r8_no_stale: assert property (@(posedge clk) disable iff (rst)
            !rd_data[SEL_LSB+i] |=> (!rd_data[SEL_LSB+i] || pin_n[i]));
    end

endmodule

bind dbgctl_pins dbgctl_pins_chk #(.DATA_W(DATA_W), .PULSE_W(PULSE_W)) u_chk (.*);

// File: tb/sim_dbgctl_pins.sv
module sim_dbgctl_pins;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [3:0]  bp_match;
    logic [3:0]  perf_evt;
    logic [3:0]  pin_n;
    logic        trap_flag;
    logic        branch_rec_en, step_on_branch, trace_msg_en;
    logic        step_each_insn, step_branch_only;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dbgctl_pins u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .bp_match(bp_match), .perf_evt(perf_evt), .pin_n(pin_n),
        .trap_flag(trap_flag), .branch_rec_en(branch_rec_en),
        .step_on_branch(step_on_branch), .trace_msg_en(trace_msg_en),
        .step_each_insn(step_each_insn), .step_branch_only(step_branch_only)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        tick();
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        bp_match = '0; perf_evt = '0; trap_flag = 1'b0;
        @(negedge clk);
        tick();
        rst = 1'b0;
        tick();
        // R1
        chk("R1 word", rd_data, 32'h0);
        chk("R1 pins", {28'h0, pin_n}, 32'hF);
        chk("R1 enables", {29'h0, branch_rec_en, step_on_branch, trace_msg_en}, 32'h0);

        // R2 R3: every live-bit value with varied reserved bits
        for (int v = 0; v < 128; v++) begin
            logic [24:0] hi;
            hi = 25'h1FFFFFF ^ 25'(v * 12345);
            wr({hi, v[6:0]});
            chk("R2 readback", rd_data, {25'h0, v[6:0]});
            chk("R3 enables", {29'h0, branch_rec_en, step_on_branch, trace_msg_en},
                {29'h0, v[0], v[1], v[6]});
            chk("R4 idle pins", {28'h0, pin_n}, 32'hF);
        end

        // R9: trap flag decode
        for (int b = 0; b < 2; b++) begin
            for (int t = 0; t < 2; t++) begin
                wr({30'h0, b[0], 1'b0});
                trap_flag = t[0];
                #1;
                chk("R9 step", {30'h0, step_each_insn, step_branch_only},
                    {30'h0, t[0] & ~b[0], t[0] & b[0]});
            end
        end
        trap_flag = 1'b0;

        // R7 R8: event mode, matches held high throughout
        wr(32'h0000_0043);
        bp_match = 4'hF;
        for (int p = 0; p < 16; p++) begin
            perf_evt = p[3:0];
            #1;
            chk("R7 follow", {28'h0, pin_n}, {28'h0, ~p[3:0]});
            tick();
            chk("R8 ignored", {28'h0, pin_n}, {28'h0, ~p[3:0]});
            chk("R7 word", rd_data, 32'h0000_0043);
        end
        bp_match = 4'h0;
        perf_evt = 4'hF;
        wr(32'h0000_003C);
        chk("R8 no stale", {28'h0, pin_n}, 32'hF);
        tick();
        chk("R8 still idle", {28'h0, pin_n}, 32'hF);

        // R5: every match pattern, events ignored in breakpoint mode
        for (int m = 0; m < 16; m++) begin
            bp_match = m[3:0];
            tick();
            bp_match = 4'h0;
            chk("R5 low", {28'h0, pin_n}, {28'h0, ~m[3:0]});
            tick();
            chk("R5 one cycle", {28'h0, pin_n}, 32'hF);
        end

        // R6: consecutive matches keep pin 1 low
        bp_match = 4'h2;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6 held", {28'h0, pin_n}, 32'hD);
        end
        bp_match = 4'h0;
        tick();
        chk("R6 release", {28'h0, pin_n}, 32'hF);

        // R4: mixed selection, pins 0 and 2 breakpoint, pins 1 and 3 events
        wr(32'h0000_0014);
        perf_evt = 4'hF;
        bp_match = 4'hF;
        tick();
        bp_match = 4'h0;
        chk("R4 mixed all low", {28'h0, pin_n}, 32'h0);
        perf_evt = 4'hA;
        tick();
        chk("R4 mixed events", {28'h0, pin_n}, 32'h5);
        perf_evt = 4'h5;
        #1;
        chk("R4 breakpoint pins ignore events", {28'h0, pin_n}, 32'hF);

        // R1: reset again after activity
        rst = 1'b1;
        perf_evt = 4'h0;
        tick();
        rst = 1'b0;
        chk("R1 re-reset", rd_data, 32'h0);
        chk("R1 re-reset pins", {28'h0, pin_n}, 32'hF);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule